// File: doc/BRIEF.md
# Processor Idle State Sequencer

This block puts a single processor into one of two deeper idle levels and brings it back to the running state. Software enters an idle level by *reading* a per-level entry register on a simple register bus. The block then stops the processor clock, and for the deepest level it also raises a deep-sleep control. It holds the processor there until an allowed wake condition appears. A pending interrupt always wakes the processor. A bus-master request wakes it only from the deep level, and only while the reload enable input is set. In the lighter level, snooping keeps running, so bus-master traffic is allowed to continue without a wake.

The block also keeps a sticky flag that records bus-master activity, which software clears by writing a one to it. It gates the bus-master grant with an arbitration-disable input, so that no master writes memory while the caches are not snooped. A status register reports the current idle level. The shallowest hardware-halt level needs no chipset help and is not sequenced here.

Top module: `idle_seq`

## Requirements
- R1: In the running state, a read of `LVL2_ADDR` with no interrupt pending moves the block to the light idle level, and a read of `LVL3_ADDR` moves it to the deep level. The change takes effect on the clock edge that samples the read. The state codes are run = 0, light = 2 and deep = 3.
- R2: `clk_stop` is registered. It is high exactly in the cycles that follow an edge at which the state was light or deep, so it rises one cycle after the entry read has been taken.
- R3: While the block is idle, a high `irq_pending` at an edge returns the state to run at that edge. An entry read made while `irq_pending` is high is ignored, and the block stays in run.
- R4: In the deep level, `bm_req` together with `bm_reload_en` returns the state to run. When `bm_reload_en` is low, `bm_req` leaves the deep level unchanged.
- R5: In the light level, `bm_req` never causes an exit, whatever the value of `bm_reload_en`. Entry reads made while the block is idle are ignored.
- R6: `bm_status` is set one edge after any cycle in which `bm_req` is high. It stays set until a write to `STS_ADDR` with data bit 2 set, and a set in the same cycle wins over the clear.
- R7: `bm_gate` is the registered value of `bm_req` AND NOT `arb_disable`.
- R8: `deep_sleep` is registered. It is high exactly in the cycles that follow an edge at which the state was deep.
- R9: `bus_rdata` is registered and is updated for every cycle. A read of `STS_ADDR` returns the state code in bits [1:0] and `bm_status` in bit 2, both as they were before the edge. Every other cycle returns zero, and this includes entry reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq_pending | input | 1 | Interrupt waiting for the processor |
| bm_req | input | 1 | Bus-master request |
| bm_reload_en | input | 1 | Lets bus-master requests wake the deep level |
| arb_disable | input | 1 | Blocks bus-master grants |
| clk_stop | output | 1 | Processor clock stop control |
| deep_sleep | output | 1 | Deep idle control |
| bm_status | output | 1 | Sticky bus-master activity flag |
| bm_gate | output | 1 | Bus-master grant gate |

## Verification
The bench builds the block with `ADDR_W` = 6 and `DATA_W` = 16. It places the status register at 0x20 and the two entry registers at 0x24 and 0x25. Because the entry addresses differ from the status address only in the low bits, a decoder that checks too few address bits will misdecode them, and the bench sees this. The narrow data width leaves room to check that the upper bits of the read data stay zero.

// File: rtl/idle_seq_pkg.sv
`timescale 1ns/1ps
package idle_seq_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_LITE = 2'd2,
    ST_DEEP = 2'd3
  } idle_state_t;

  localparam int STS_BM_BIT = 2;

  function automatic logic is_idle(idle_state_t s);
    return s != ST_RUN;
  endfunction
endpackage

// File: rtl/idle_bus_decode.sv
`timescale 1ns/1ps
module idle_bus_decode
  import idle_seq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] STS_ADDR  = 'h10,
  parameter logic [ADDR_W-1:0] LVL2_ADDR = 'h14,
  parameter logic [ADDR_W-1:0] LVL3_ADDR = 'h15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  idle_state_t       cur_state,
  input  logic              bm_req,
  output logic              ent_lite,
  output logic              ent_deep,
  output logic              bm_sts,
  output logic [DATA_W-1:0] rdata
);
  logic hit_sts, hit_l2, hit_l3, clr_bm;
  logic wdata_unused;

  assign hit_sts  = bus_addr == STS_ADDR;
  assign hit_l2   = bus_addr == LVL2_ADDR;
  assign hit_l3   = bus_addr == LVL3_ADDR;
  assign ent_lite = bus_rd && hit_l2;
  assign ent_deep = bus_rd && hit_l3;
  assign clr_bm   = bus_wr && hit_sts && bus_wdata[STS_BM_BIT];
  assign wdata_unused = ^{bus_wdata[DATA_W-1:STS_BM_BIT+1], bus_wdata[STS_BM_BIT-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      bm_sts <= 1'b0;
    end else if (bm_req) begin
      bm_sts <= 1'b1;
    end else if (clr_bm) begin
      bm_sts <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      rdata <= '0;
      if (bus_rd && hit_sts) begin
        rdata[1:0]        <= cur_state;
        rdata[STS_BM_BIT] <= bm_sts;
      end
    end
  end

  assert_bm_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    bm_req |=> bm_sts);
  assert_bm_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (bm_sts && !bus_wr) |=> bm_sts);
  assert_entry_read_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && (hit_l2 || hit_l3)) |=> (rdata == '0));
endmodule

// File: rtl/idle_state_fsm.sv
`timescale 1ns/1ps
module idle_state_fsm
  import idle_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        ent_lite,
  input  logic        ent_deep,
  input  logic        irq_pending,
  input  logic        bm_req,
  input  logic        bm_reload_en,
  output idle_state_t state
);
  idle_state_t nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_RUN: begin
        if (!irq_pending) begin
          if (ent_deep)      nxt = ST_DEEP;
          else if (ent_lite) nxt = ST_LITE;
        end
      end
      ST_LITE: if (irq_pending) nxt = ST_RUN;
      ST_DEEP: if (irq_pending || (bm_req && bm_reload_en)) nxt = ST_RUN;
      default: nxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_RUN;
    else     state <= nxt;
  end

  assert_irq_wakes_R3: assert property (@(posedge clk) disable iff (rst)
    (is_idle(state) && irq_pending) |=> (state == ST_RUN));
  assert_irq_blocks_entry_R3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && irq_pending) |=> (state == ST_RUN));
  assert_deep_reload_exit_R4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DEEP && bm_req && bm_reload_en) |=> (state == ST_RUN));
  assert_deep_no_reload_R4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DEEP && !irq_pending && !bm_reload_en) |=> (state == ST_DEEP));
  assert_lite_holds_R5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LITE && !irq_pending) |=> (state == ST_LITE));
endmodule

// File: rtl/idle_ctrl_outs.sv
`timescale 1ns/1ps
module idle_ctrl_outs
  import idle_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  idle_state_t state,
  input  logic        bm_req,
  input  logic        arb_disable,
  output logic        clk_stop,
  output logic        deep_sleep,
  output logic        bm_gate
);
  always_ff @(posedge clk) begin
    if (rst) begin
      clk_stop   <= 1'b0;
      deep_sleep <= 1'b0;
      bm_gate    <= 1'b0;
    end else begin
      clk_stop   <= is_idle(state);
      deep_sleep <= state == ST_DEEP;
      bm_gate    <= bm_req && !arb_disable;
    end
  end

  assert_run_clock_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && $past(state) == ST_RUN) |-> !clk_stop);
  assert_deep_implies_stop_R8: assert property (@(posedge clk) disable iff (rst)
    deep_sleep |-> clk_stop);
  assert_arb_blocks_R7: assert property (@(posedge clk) disable iff (rst)
    arb_disable |=> !bm_gate);
endmodule

// File: rtl/idle_seq.sv
`timescale 1ns/1ps
module idle_seq
  import idle_seq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] STS_ADDR  = 'h10,
  parameter logic [ADDR_W-1:0] LVL2_ADDR = 'h14,
  parameter logic [ADDR_W-1:0] LVL3_ADDR = 'h15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              irq_pending,
  input  logic              bm_req,
  input  logic              bm_reload_en,
  input  logic              arb_disable,
  output logic              clk_stop,
  output logic              deep_sleep,
  output logic              bm_status,
  output logic              bm_gate
);
  idle_state_t state;
  logic ent_lite, ent_deep;

  idle_bus_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .STS_ADDR(STS_ADDR), .LVL2_ADDR(LVL2_ADDR), .LVL3_ADDR(LVL3_ADDR)
  ) u_dec (
    .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cur_state(state),
    .bm_req(bm_req), .ent_lite(ent_lite), .ent_deep(ent_deep),
    .bm_sts(bm_status), .rdata(bus_rdata)
  );

  idle_state_fsm u_fsm (
    .clk(clk), .rst(rst), .ent_lite(ent_lite), .ent_deep(ent_deep),
    .irq_pending(irq_pending), .bm_req(bm_req),
    .bm_reload_en(bm_reload_en), .state(state)
  );

  idle_ctrl_outs u_out (
    .clk(clk), .rst(rst), .state(state), .bm_req(bm_req),
    .arb_disable(arb_disable), .clk_stop(clk_stop),
    .deep_sleep(deep_sleep), .bm_gate(bm_gate)
  );

  initial begin
    assert_params_R9: assert (DATA_W >= 8 && ADDR_W >= 2);
  end
endmodule

// File: tb/idle_seq_test.sv
`timescale 1ns/1ps
module idle_seq_test;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam logic [AW-1:0] A_STS = 6'h20;
  localparam logic [AW-1:0] A_L2  = 6'h24;
  localparam logic [AW-1:0] A_L3  = 6'h25;

  logic clk = 1'b0, rst = 1'b1;
  logic bus_rd = 0, bus_wr = 0, irq_pending = 0, bm_req = 0, bm_reload_en = 0, arb_disable = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic clk_stop, deep_sleep, bm_status, bm_gate;

  idle_seq #(.ADDR_W(AW), .DATA_W(DW), .STS_ADDR(A_STS), .LVL2_ADDR(A_L2), .LVL3_ADDR(A_L3)) uut (
    .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_pending(irq_pending),
    .bm_req(bm_req), .bm_reload_en(bm_reload_en), .arb_disable(arb_disable),
    .clk_stop(clk_stop), .deep_sleep(deep_sleep), .bm_status(bm_status), .bm_gate(bm_gate)
  );

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  logic chk_en = 1'b0, done = 1'b0;

  // Reference model (codes: run 0, light 2, deep 3)
  logic [1:0] e_st = 2'd0;
  logic e_cs = 0, e_ds = 0, e_bms = 0, e_gate = 0;
  logic [DW-1:0] e_rd = '0;

  function automatic logic [1:0] next_st(logic [1:0] s, logic rd, logic [AW-1:0] a,
                                         logic irq, logic bmr, logic rld);
    case (s)
      2'd0: if (rd && !irq && a == A_L3) return 2'd3;
            else if (rd && !irq && a == A_L2) return 2'd2;
            else return 2'd0;
      2'd2: return irq ? 2'd0 : 2'd2;
      default: return (irq || (bmr && rld)) ? 2'd0 : 2'd3;
    endcase
  endfunction

  function automatic logic [DW-1:0] status_word(logic [1:0] s, logic b);
    logic [DW-1:0] w = '0;
    w[1:0] = s;
    w[2] = b;
    return w;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      e_st <= 2'd0; e_cs <= 0; e_ds <= 0; e_bms <= 0; e_gate <= 0; e_rd <= '0;
    end else begin
      e_st   <= next_st(e_st, bus_rd, bus_addr, irq_pending, bm_req, bm_reload_en);
      e_cs   <= e_st != 2'd0;
      e_ds   <= e_st == 2'd3;
      e_gate <= bm_req && !arb_disable;
      e_bms  <= bm_req ? 1'b1 : ((bus_wr && bus_addr == A_STS && bus_wdata[2]) ? 1'b0 : e_bms);
      e_rd   <= (bus_rd && bus_addr == A_STS) ? status_word(e_st, e_bms) : '0;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chk_en && !done) begin
      chk("R2 clk_stop", {31'd0, clk_stop}, {31'd0, e_cs});
      chk("R8 deep_sleep", {31'd0, deep_sleep}, {31'd0, e_ds});
      chk("R6 bm_status", {31'd0, bm_status}, {31'd0, e_bms});
      chk("R7 bm_gate", {31'd0, bm_gate}, {31'd0, e_gate});
      chk("R9 rdata", {16'd0, bus_rdata}, {16'd0, e_rd});
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic drive(logic rd, logic wr, logic [AW-1:0] a, logic [DW-1:0] wd,
                       logic irq, logic bmr, logic rld, logic arb);
    bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd;
    irq_pending = irq; bm_req = bmr; bm_reload_en = rld; arb_disable = arb;
    @(negedge clk);
  endtask

  task automatic idle_cycle();
    drive(0, 0, '0, '0, 0, 0, 0, 0);
  endtask

  task automatic read_status(output logic [DW-1:0] v);
    drive(1, 0, A_STS, '0, 0, 0, 0, 0);
    v = bus_rdata;
  endtask

  logic [DW-1:0] sv;

  initial begin
    repeat (3) @(negedge clk);
    chk("R2 reset clk_stop", {31'd0, clk_stop}, 0);
    chk("R8 reset deep_sleep", {31'd0, deep_sleep}, 0);
    chk("R6 reset bm_status", {31'd0, bm_status}, 0);
    rst = 0;
    chk_en = 1;
    idle_cycle();

    // R1/R5: light entry, bus-master traffic with reload set does not wake
    drive(1, 0, A_L2, '0, 0, 0, 0, 0);
    chk("R9 entry read returns zero", {16'd0, bus_rdata}, 0);
    drive(0, 0, '0, '0, 0, 1, 1, 0);
    drive(0, 0, '0, '0, 0, 1, 1, 0);
    drive(0, 0, '0, '0, 0, 1, 1, 1);
    chk("R5 light held under bm_req", {31'd0, clk_stop}, 1);
    read_status(sv);
    chk("R1 status light code", {30'd0, sv[1:0]}, 2);
    drive(1, 0, A_L3, '0, 0, 0, 0, 0);   // ignored while idle (R5)
    idle_cycle();
    chk("R5 idle entry read ignored", {31'd0, deep_sleep}, 0);
    drive(0, 0, '0, '0, 1, 0, 0, 0);     // irq wakes (R3)
    idle_cycle();
    chk("R3 irq exits light", {31'd0, clk_stop}, 0);

    // R4: deep level, reload low holds, reload high wakes
    drive(1, 0, A_L3, '0, 0, 0, 0, 0);
    drive(0, 0, '0, '0, 0, 1, 0, 1);
    drive(0, 0, '0, '0, 0, 1, 0, 1);
    chk("R4 deep held without reload", {31'd0, deep_sleep}, 1);
    chk("R7 gate blocked by arb_disable", {31'd0, bm_gate}, 0);
    drive(0, 0, '0, '0, 0, 1, 1, 0);
    idle_cycle();
    chk("R4 deep exits with reload", {31'd0, deep_sleep}, 0);

    // R3: entry read with irq pending ignored
    drive(1, 0, A_L2, '0, 1, 0, 0, 0);
    idle_cycle();
    chk("R3 entry blocked by irq", {31'd0, clk_stop}, 0);

    // R6: clear by write-1, set wins over clear
    drive(0, 1, A_STS, 16'h0004, 0, 0, 0, 0);
    chk("R6 cleared by write one", {31'd0, bm_status}, 0);
    drive(0, 1, A_STS, 16'h0004, 0, 1, 0, 0);
    chk("R6 set wins over clear", {31'd0, bm_status}, 1);
    drive(0, 1, A_STS, 16'hFFFB, 0, 0, 0, 0);
    chk("R6 write zero keeps flag", {31'd0, bm_status}, 1);
    read_status(sv);
    chk("R9 status word", {16'd0, sv}, 32'h4);

    // Constrained random
    void'($urandom(32'h1D1E5EED));
    for (int i = 0; i < 4000; i++) begin
      logic [AW-1:0] a;
      logic [2:0] pick;
      pick = 3'($urandom_range(0, 4));
      a = (pick == 0) ? A_L2 : (pick == 1) ? A_L3 : (pick == 2) ? A_STS :
          (pick == 3) ? (A_L2 ^ 6'h10) : AW'($urandom);
      drive(($urandom_range(0, 2) == 0), ($urandom_range(0, 7) == 0), a, DW'($urandom),
            ($urandom_range(0, 9) == 0), $urandom_range(0, 1) == 1,
            $urandom_range(0, 1) == 1, ($urandom_range(0, 3) == 0));
    end
    idle_cycle();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule